// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge sits between a CPU-side request port and a byte-addressable, little-endian memory. Two 32 MiB alias windows, based at 0x2200_0000 and 0x4200_0000, are decoded. Each aligned word in a window stands for a single bit of real memory. An alias read returns that bit as 0 or 1. An alias write sets or clears that bit, using bit 0 of the write data, through a locked read-modify-write of the backing unit.

Any address outside the two windows goes straight to the memory. Its size, byte lanes and data are unchanged, and it costs one memory transaction. The memory answers reads with one cycle of latency. The bridge drops `s_ready` while an alias sequence runs, so no other access can come between the read and the write-back of that sequence.

Byte, halfword and word access sizes are supported. The access size sets how wide the backing unit is, and so how many alias words map onto it.

Top module: `bitband_bridge`

## Requirements
- R1: After synchronous reset the bridge is idle. `s_ready` is 1, `s_rvalid` is 0 and no memory request is driven while `s_req` is low.
- R2: An address is an alias address exactly when bits [31:25] equal 0x11 (window 0x2200_0000–0x23FF_FFFF) or 0x21 (window 0x4200_0000–0x43FF_FFFF). Every other address, including the words just outside each window, passes through.
- R3: The backing byte address is built from two parts. Bits [31:29] of the alias address are kept as they are. The low bits are alias bits [24:0] shifted right by 5. Bits [28:20] of the result are zero.
- R4: The bit index inside the backing unit comes from the alias address. It is bits [4:2] for size code 0 (byte), bits [5:2] for size code 1 (halfword) and bits [6:2] for size code 2 (word).
- R5: An alias read returns the selected bit in `s_rdata` bit 0, and bits [31:1] are zero. `s_rvalid` is high in the second cycle after acceptance.
- R6: An alias write sets the selected bit when `s_wdata[0]` is 1 and clears it when it is 0. It writes the whole unit back, so every other bit of the memory word is preserved. The unit sits on little-endian lanes: byte offset n holds word bits [8n+7:8n].
- R7: On an alias write, `s_wdata` bits [31:1] have no effect on memory.
- R8: An alias read holds `s_ready` low for 2 cycles and issues one memory read. An alias write holds `s_ready` low for 3 cycles and issues a memory read followed by a memory write. The write is committed at the third clock edge after acceptance.
- R9: A pass-through access is issued in the cycle it is accepted, as exactly one memory transaction. Its address, write flag and data are unchanged. The byte enables are one lane at addr[1:0] for a byte, two lanes at addr[1] for a halfword, and all four for a word. Read data returns, as the full memory word, in the cycle after acceptance.
- R10: The backing unit address is aligned to the access size. Bit 0 is cleared for a halfword, and bits [1:0] are cleared for a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | CPU request valid |
| s_we | input | 1 | CPU write (1) or read (0) |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | CPU byte address |
| s_wdata | input | 32 | CPU write data, lane-placed |
| s_ready | output | 1 | Bridge can accept a request this cycle |
| s_rvalid | output | 1 | Read response valid |
| s_rdata | output | 32 | Read response data |
| m_req | output | 1 | Memory request valid |
| m_we | output | 1 | Memory write (1) or read (0) |
| m_addr | output | 32 | Memory byte address |
| m_be | output | 4 | Memory byte-lane enables |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
Results fall due at different times for each kind of access.

- **Pass-through read:** data is due one cycle after acceptance, and the bench samples it at the first falling edge after the accepting edge.
- **Alias read:** the bit is due one cycle later, at the second falling edge.
- **Alias write:** it reaches memory at the third rising edge after acceptance. The bench compares the memory word only once `s_ready` has come back.

At that same point the bench also checks how many cycles `s_ready` was low and how many memory requests the access caused.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned LANES = BUS_W / 8;
    localparam int unsigned POS_W = $clog2(BUS_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_MODIFY,
        ST_WR,
        ST_RESP
    } rmw_state_e;

    // Result of decoding one CPU address against the alias windows
    typedef struct packed {
        logic             hit;
        logic [BUS_W-1:0] unit_addr;
        logic [POS_W-1:0] bit_pos;
        logic [LANES-1:0] lanes;
    } alias_map_t;

    // Byte lanes touched by an access of a given size at a given offset
    function automatic logic [LANES-1:0] lane_mask(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lo;
            SZ_HALF: return 4'b0011 << {lo[1], 1'b0};
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/bb_decode.sv
`timescale 1ns/1ps
module bb_decode
    import bb_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 2,
    parameter logic [NUM_WIN-1:0][31:0] WIN_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter int unsigned WIN_LOG2  = 25,
    parameter int unsigned KEEP_LSB  = 29,
    parameter int unsigned BIT_SHIFT = 5
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output alias_map_t  map
);
    localparam logic [31:0] LO_MASK = (32'd1 << WIN_LOG2) - 32'd1;
    localparam logic [31:0] HI_MASK = ~((32'd1 << KEEP_LSB) - 32'd1);

    logic [NUM_WIN-1:0] win_hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w] = (addr[31:WIN_LOG2] == WIN_BASE[w][31:WIN_LOG2]);
    end

    logic [31:0] tgt;
    logic [31:0] unit_a;
    logic [4:0]  idx;

    always_comb begin
        tgt    = (addr & HI_MASK) | ((addr & LO_MASK) >> BIT_SHIFT);
        unit_a = tgt;
        idx    = '0;
        case (size)
            SZ_BYTE: begin
                unit_a = tgt;
                idx    = {2'b00, addr[4:2]};
            end
            SZ_HALF: begin
                unit_a = {tgt[31:1], 1'b0};
                idx    = {1'b0, addr[5:2]};
            end
            default: begin
                unit_a = {tgt[31:2], 2'b00};
                idx    = addr[6:2];
            end
        endcase
        map.hit       = |win_hit;
        map.unit_addr = unit_a;
        map.bit_pos   = {unit_a[1:0], 3'b000} + idx;
        map.lanes     = lane_mask(size, unit_a[1:0]);
    end

endmodule

// File: rtl/bb_rmw_fsm.sv
`timescale 1ns/1ps
module bb_rmw_fsm
    import bb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_write,
    input  logic        set_val,
    input  alias_map_t  map_in,
    input  logic [31:0] mem_rdata,
    output rmw_state_e  state,
    output alias_map_t  map_q,
    output logic [31:0] wb_word
);
    rmw_state_e  nxt;
    logic        we_q;
    logic        val_q;
    logic [31:0] sel;

    assign sel = 32'd1 << map_q.bit_pos;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start) nxt = ST_RD;
            ST_RD:     nxt = we_q ? ST_MODIFY : ST_RESP;
            ST_MODIFY: nxt = ST_WR;
            ST_WR:     nxt = ST_IDLE;
            ST_RESP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            we_q    <= 1'b0;
            val_q   <= 1'b0;
            map_q   <= '0;
            wb_word <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                map_q <= map_in;
                we_q  <= is_write;
                val_q <= set_val;
            end
            if (state == ST_MODIFY)
                wb_word <= val_q ? (mem_rdata | sel) : (mem_rdata & ~sel);
        end
    end

    // R8
    modify_only_for_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MODIFY) |-> $past(state == ST_RD) && we_q);

endmodule

// File: rtl/bitband_bridge.sv
`timescale 1ns/1ps
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 2,
    parameter logic [NUM_WIN-1:0][31:0] WIN_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter int unsigned WIN_LOG2  = 25,
    parameter int unsigned KEEP_LSB  = 29,
    parameter int unsigned BIT_SHIFT = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [1:0]  s_size,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic        s_rvalid,
    output logic [31:0] s_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [3:0]  m_be,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata
);
    alias_map_t  amap;
    alias_map_t  map_q;
    rmw_state_e  state;
    logic [31:0] wb_word;
    logic        accept;
    logic        pass;
    logic        pt_rd_q;

    bb_decode #(
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2),
        .KEEP_LSB (KEEP_LSB),
        .BIT_SHIFT(BIT_SHIFT)
    ) u_decode (
        .addr(s_addr),
        .size(s_size),
        .map (amap)
    );

    assign s_ready = (state == ST_IDLE);
    assign accept  = s_req && s_ready;
    assign pass    = accept && !amap.hit;

    bb_rmw_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && amap.hit),
        .is_write (s_we),
        .set_val  (s_wdata[0]),
        .map_in   (amap),
        .mem_rdata(m_rdata),
        .state    (state),
        .map_q    (map_q),
        .wb_word  (wb_word)
    );

    always_comb begin
        m_req   = pass || (state == ST_RD) || (state == ST_WR);
        m_we    = pass ? s_we : (state == ST_WR);
        m_addr  = pass ? s_addr : map_q.unit_addr;
        m_be    = pass ? lane_mask(s_size, s_addr[1:0]) : map_q.lanes;
        m_wdata = pass ? s_wdata : wb_word;
    end

    always_ff @(posedge clk) begin
        if (rst) pt_rd_q <= 1'b0;
        else     pt_rd_q <= pass && !s_we;
    end

    assign s_rvalid = pt_rd_q || (state == ST_RESP);
    assign s_rdata  = (state == ST_RESP) ? {31'b0, m_rdata[map_q.bit_pos]}
                    : (pt_rd_q ? m_rdata : '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (s_ready && !s_rvalid));

    // R5
    alias_rd_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && amap.hit && !s_we) |=> ##1 (s_rvalid && s_rdata[31:1] == '0));

    // R8
    alias_rd_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && amap.hit && !s_we) |=> (!s_ready && m_req && !m_we) ##1 !s_ready ##1 s_ready);

    // R8
    alias_wr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && amap.hit && s_we) |=> (!s_ready && m_req && !m_we) ##1 (!s_ready && !m_req)
                                         ##1 (!s_ready && m_req && m_we) ##1 s_ready);

    // R2
    busy_is_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !s_ready) |-> map_q.hit);

    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_ready && !amap.hit) |-> (m_req && m_addr == s_addr && m_we == s_we));

endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        s_req, s_we;
    logic [1:0]  s_size;
    logic [31:0] s_addr, s_wdata;
    logic        s_ready, s_rvalid;
    logic [31:0] s_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [3:0]  m_be;
    logic [31:0] m_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int mreq_cnt = 0;

    logic [31:0] mem    [512];
    logic [31:0] shadow [512];

    always #4 clk = ~clk;

    bitband_bridge dut (
        .clk(clk), .rst(rst),
        .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be),
        .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    function automatic int widx(logic [31:0] a);
        return int'({a[30], a[9:2]});
    endfunction

    // memory model: one-cycle read latency, byte-lane writes
    always @(posedge clk) begin
        if (m_req) begin
            mreq_cnt <= mreq_cnt + 1;
            if (m_we) begin
                for (int b = 0; b < 4; b++)
                    if (m_be[b]) mem[widx(m_addr)][8*b +: 8] <= m_wdata[8*b +: 8];
            end else begin
                m_rdata <= mem[widx(m_addr)];
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // expected alias mapping, from the requirements
    task automatic bmap(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] ua, output int pos);
        logic [31:0] t;
        t = {a[31:29], 29'b0} | ((a & 32'h01FF_FFFF) >> 5);
        case (sz)
            2'd0: begin ua = t;                  pos = 8 * int'(t[1:0]) + int'(a[4:2]); end
            2'd1: begin ua = {t[31:1], 1'b0};    pos = 16 * int'(t[1]) + int'(a[5:2]); end
            default: begin ua = {t[31:2], 2'b00}; pos = int'(a[6:2]); end
        endcase
    endtask

    function automatic logic [3:0] exp_lanes(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0: return 4'b0001 << lo;
            2'd1: return 4'b0011 << {lo[1], 1'b0};
            default: return 4'b1111;
        endcase
    endfunction

    // one access; lat 1 samples read data at the first falling edge after acceptance, lat 2 at the second
    task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                          input int lat, output logic rv, output logic [31:0] rd, output int busy, output int nreq);
        int c0;
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_size = sz; s_addr = a; s_wdata = wd;
        c0 = mreq_cnt;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
        busy = 0;
        rv = s_rvalid; rd = s_rdata;
        if (!s_ready) busy++;
        @(negedge clk);
        if (lat == 2) begin rv = s_rvalid; rd = s_rdata; end
        while (!s_ready) begin busy++; @(negedge clk); end
        nreq = mreq_cnt - c0;
    endtask

    task automatic alias_read(input logic [1:0] sz, input logic [31:0] a, input string tag);
        logic rv; logic [31:0] rd, ua; int busy, nreq, pos;
        bmap(a, sz, ua, pos);
        access(1'b0, sz, a, 32'h0, 2, rv, rd, busy, nreq);
        check(rv == 1'b1, {tag, " R5 rvalid"}, 32'(rv), 32'd1);
        check(rd == {31'b0, shadow[widx(ua)][pos]}, {tag, " R3 R4 R5 R10 bit value"}, rd, {31'b0, shadow[widx(ua)][pos]});
        check(busy == 2 && nreq == 1, {tag, " R8 read lock"}, 32'(busy * 16 + nreq), 32'h21);
    endtask

    task automatic alias_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd, input string tag);
        logic rv; logic [31:0] rd, ua; int busy, nreq, pos;
        bmap(a, sz, ua, pos);
        shadow[widx(ua)][pos] = wd[0];
        access(1'b1, sz, a, wd, 2, rv, rd, busy, nreq);
        check(mem[widx(ua)] == shadow[widx(ua)], {tag, " R6 R7 memory word"}, mem[widx(ua)], shadow[widx(ua)]);
        check(busy == 3 && nreq == 2, {tag, " R8 write lock"}, 32'(busy * 16 + nreq), 32'h32);
    endtask

    task automatic pass_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd, input string tag);
        logic rv; logic [31:0] rd; int busy, nreq;
        logic [3:0] ln;
        ln = exp_lanes(sz, a[1:0]);
        for (int b = 0; b < 4; b++)
            if (ln[b]) shadow[widx(a)][8*b +: 8] = wd[8*b +: 8];
        access(1'b1, sz, a, wd, 1, rv, rd, busy, nreq);
        check(mem[widx(a)] == shadow[widx(a)], {tag, " R2 R9 pass write"}, mem[widx(a)], shadow[widx(a)]);
        check(busy == 0 && nreq == 1, {tag, " R9 single transaction"}, 32'(busy * 16 + nreq), 32'h01);
    endtask

    task automatic pass_read(input logic [1:0] sz, input logic [31:0] a, input string tag);
        logic rv; logic [31:0] rd; int busy, nreq;
        access(1'b0, sz, a, 32'h0, 1, rv, rd, busy, nreq);
        check(rv && rd == shadow[widx(a)], {tag, " R9 pass read"}, rd, shadow[widx(a)]);
        check(busy == 0 && nreq == 1, {tag, " R9 single transaction"}, 32'(busy * 16 + nreq), 32'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] bases [2];
        bases[0] = 32'h2200_0000;
        bases[1] = 32'h4200_0000;
        for (int i = 0; i < 512; i++) begin
            mem[i]    = (32'(i) * 32'h9E37_79B9) ^ 32'h1234_5678;
            shadow[i] = mem[i];
        end
        rst = 1'b1; s_req = 1'b0; s_we = 1'b0; s_size = 2'd0; s_addr = '0; s_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(s_ready == 1'b1, "R1 ready after reset", 32'(s_ready), 32'd1);
        check(s_rvalid == 1'b0, "R1 no response after reset", 32'(s_rvalid), 32'd0);
        check(m_req == 1'b0, "R1 no memory request after reset", 32'(m_req), 32'd0);

        // read sweep over both windows, all sizes
        for (int w = 0; w < 2; w++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 128; off++)
                    alias_read(2'(sz), bases[w] + 32'(off) * 32'd4, "sweep");

        // write sweep, upper write-data bits carry garbage (R7)
        for (int w = 0; w < 2; w++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 64; off++) begin
                    logic bv;
                    bv = off[0] ^ off[2] ^ sz[0];
                    alias_write(2'(sz), bases[w] + 32'(off) * 32'd4,
                                {31'h2AAA_5555 ^ 31'(off * 3), bv}, "wsweep");
                end

        // R7: all-ones upper bits with bit0 clear must clear; bit0 alone must set
        alias_write(2'd2, 32'h2200_0000 + 32'd20, 32'hFFFF_FFFE, "R7 clear");
        alias_read (2'd2, 32'h2200_0000 + 32'd20, "R7 clear readback");
        alias_write(2'd2, 32'h2200_0000 + 32'd20, 32'h0000_0001, "R7 set");
        alias_read (2'd2, 32'h2200_0000 + 32'd20, "R7 set readback");

        // R2 boundaries: last alias word of each window
        alias_read (2'd0, 32'h23FF_FFFC, "R2 window0 top");
        alias_write(2'd0, 32'h23FF_FFFC, 32'h0, "R2 window0 top");
        alias_read (2'd2, 32'h43FF_FFFC, "R2 window1 top");
        alias_write(2'd2, 32'h43FF_FFFC, 32'h1, "R2 window1 top");

        // R9 lanes in plain memory
        pass_write(2'd2, 32'h2000_0200, 32'hCAFE_F00D, "R9 word");
        pass_write(2'd0, 32'h2000_0201, 32'h0000_AB00, "R9 byte lane1");
        pass_write(2'd1, 32'h2000_0202, 32'h1357_0000, "R9 upper half");
        pass_write(2'd0, 32'h2000_0207, 32'h7700_0000, "R9 byte lane3");
        pass_read (2'd2, 32'h2000_0200, "R9 word");
        pass_read (2'd0, 32'h2000_0201, "R9 byte");

        // R2: addresses just outside the windows go straight through
        pass_write(2'd2, 32'h21FF_FFFC, 32'hA5A5_0F0F, "R2 below window0");
        pass_write(2'd2, 32'h2400_0000, 32'h0123_4567, "R2 above window0");
        pass_write(2'd2, 32'h41FF_FFFC, 32'h89AB_CDEF, "R2 below window1");
        pass_write(2'd2, 32'h4400_0000, 32'hFEDC_BA98, "R2 above window1");
        pass_read (2'd2, 32'h21FF_FFFC, "R2 below window0");
        pass_read (2'd2, 32'h4400_0000, "R2 above window1");

        finish_run();
    end

endmodule